// File: doc/BRIEF.md
# CPU Bus Byte-Order Converter

This block joins a 32-bit CPU-side bus to an internal fabric whose memory and local control registers are always little-endian. The CPU byte order is taken from an input pin while reset is held and is then frozen. When the CPU is big-endian and software has set a control bit, every transfer is converted. The block reverses the byte lanes of write and read data, flips the sub-word address bits and moves the byte enables with the data. The internal side then stores and fetches exactly the bytes the CPU meant to touch.

The control bit sits in a status register inside the block, at a fixed word of the register space. Accesses to that word are served locally. Every other access is passed to the fabric with a flag that tells register space apart from memory space. The CPU issues aligned byte, halfword or word transfers and keeps at most one read outstanding.

Top module: `cpu_endian_bridge`

## Requirements
- R1: The byte-order mode is loaded from `endian_pin` on every clock edge while `rst` is high (1 = big-endian) and holds until the next reset. Changes on the pin after reset have no effect on any transfer.
- R2: The control bit resets to 0. It is bit 0 of the status word at register address 0x8000 (address MSB set, word index `STAT_WORD` = 0). A write updates it when internal byte lane 0 is enabled, and a read returns it in bit 0 of the internal word with all other bits 0.
- R3: Conversion is active only when the mode is big-endian and the control bit is 1. In the other three combinations, the fabric address, byte enables and write data equal the CPU values, and read data is returned unchanged.
- R4: While conversion is active, fabric write data is the CPU write data with its four bytes in reverse lane order. The bit order inside each byte is kept.
- R5: While conversion is active, the low two address bits are XORed with 2'b11 for byte transfers (size 0) and with 2'b10 for halfword transfers (size 1). They are left unchanged for word transfers (size 2).
- R6: Fabric byte enables select exactly 2^size lanes. These are the lanes of the transfer at the internal (remapped) address, where lane n carries data bits 8n+7..8n.
- R7: While conversion is active, read data returned to the CPU is the fabric or status word with its bytes in reverse lane order. A round trip through memory returns the CPU's own bytes.
- R8: Fabric request outputs appear on the clock edge after the CPU request is sampled. `cpu_rvalid` with data rises on the edge after `fab_rvalid`. A status-register read completes on the third edge counting the request edge.
- R9: A change of the control bit applies to the very next transfer.
- R10: Accesses to the status word never raise `fab_req`. For all other accesses, `fab_is_reg` equals address bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| endian_pin | input | 1 | CPU byte-order strap, 1 = big-endian, sampled during reset |
| cpu_req | input | 1 | CPU transfer request, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | AW | Byte address, MSB selects register space |
| cpu_wdata | input | DW | CPU write data on CPU lanes |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DW | Read data on CPU lanes |
| fab_req | output | 1 | Fabric request |
| fab_we | output | 1 | Fabric write |
| fab_is_reg | output | 1 | Register-space access |
| fab_addr | output | AW | Internal byte address |
| fab_be | output | DW/8 | Internal byte-lane enables |
| fab_wdata | output | DW | Little-endian write data |
| fab_rvalid | input | 1 | Fabric read response valid |
| fab_rdata | input | DW | Little-endian read data |

## Verification
Fabric-side outputs are due one edge after the CPU request, so the bench drives on a falling edge and samples them on the next falling edge. Read data is due two edges after the request for both the status word and a memory model that answers one edge after `fab_req`. The bench checks that `cpu_rvalid` is still low one falling edge before that point and high at it. Control-bit changes are followed by a transfer on the very next cycle, so the one-transfer effect of R9 is observed without idle gaps.

// File: rtl/endian_bridge_pkg.sv
package endian_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

endpackage

// File: rtl/endian_mode_latch.sv
module endian_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic mode_q
);

  // Strap is followed while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= pin;
  end

endmodule

// File: rtl/endian_ctl_reg.sv
module endian_ctl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic ctl_q
);

  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= 1'b0;
    else if (wr_en) ctl_q <= wr_bit;
  end

endmodule

// File: rtl/endian_lane_map.sv
module endian_lane_map #(
  parameter int NB = 4,
  localparam int LB = $clog2(NB)
) (
  input  logic          swap,
  input  logic [1:0]    size,
  input  logic [LB-1:0] addr_lo,
  output logic [LB-1:0] addr_lo_int,
  output logic [NB-1:0] be
);

  logic [LB-1:0] flip;

  always_comb begin
    // Flip every address bit at or above the transfer size.
    for (int i = 0; i < LB; i++) begin
      flip[i] = swap && (i >= int'(size));
    end
    addr_lo_int = addr_lo ^ flip;
    for (int j = 0; j < NB; j++) begin
      be[j] = ((j >> size) == (int'(addr_lo_int) >> size));
    end
  end

endmodule

// File: rtl/endian_lane_swap.sv
module endian_lane_swap #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          swap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign dout[8*g +: 8] = swap ? din[8*(NB-1-g) +: 8] : din[8*g +: 8];
  end

endmodule

// File: rtl/cpu_endian_bridge.sv
module cpu_endian_bridge #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int STAT_WORD = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            endian_pin,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [1:0]      cpu_size,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_rvalid,
  output logic [DW-1:0]   cpu_rdata,
  output logic            fab_req,
  output logic            fab_we,
  output logic            fab_is_reg,
  output logic [AW-1:0]   fab_addr,
  output logic [DW/8-1:0] fab_be,
  output logic [DW-1:0]   fab_wdata,
  input  logic            fab_rvalid,
  input  logic [DW-1:0]   fab_rdata
);
  import endian_bridge_pkg::*;

  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);
  localparam int IW = AW - 1 - LB;
  localparam logic [IW-1:0] STAT_IDX = IW'(STAT_WORD);

  logic          mode_q;
  logic          ctl_q;
  logic          swap;
  logic [LB-1:0] lo_int;
  logic [NB-1:0] be_int;
  logic [DW-1:0] wdata_int;
  logic          stat_hit;
  logic          rd_swap_q;
  logic          loc1_q, loc2_q;
  logic [DW-1:0] loc1_dat, loc2_dat;
  logic [DW-1:0] rsp_src, rsp_cpu;

  assign swap     = mode_q & ctl_q;
  assign stat_hit = cpu_addr[AW-1] && (cpu_addr[AW-2:LB] == STAT_IDX);

  endian_mode_latch u_mode (
    .clk    (clk),
    .rst    (rst),
    .pin    (endian_pin),
    .mode_q (mode_q)
  );

  endian_lane_map #(.NB(NB)) u_map (
    .swap        (swap),
    .size        (cpu_size),
    .addr_lo     (cpu_addr[LB-1:0]),
    .addr_lo_int (lo_int),
    .be          (be_int)
  );

  endian_lane_swap #(.DW(DW)) u_wswap (
    .swap (swap),
    .din  (cpu_wdata),
    .dout (wdata_int)
  );

  endian_ctl_reg u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cpu_req && cpu_we && stat_hit && be_int[0]),
    .wr_bit (wdata_int[0]),
    .ctl_q  (ctl_q)
  );

  // Registered fabric request.
  always_ff @(posedge clk) begin
    if (rst) begin
      fab_req    <= 1'b0;
      fab_we     <= 1'b0;
      fab_is_reg <= 1'b0;
      fab_addr   <= '0;
      fab_be     <= '0;
      fab_wdata  <= '0;
      rd_swap_q  <= 1'b0;
    end else begin
      fab_req <= cpu_req && !stat_hit;
      if (cpu_req) begin
        fab_we     <= cpu_we;
        fab_is_reg <= cpu_addr[AW-1];
        fab_addr   <= {cpu_addr[AW-1:LB], lo_int};
        fab_be     <= be_int;
        fab_wdata  <= wdata_int;
        if (!cpu_we) rd_swap_q <= swap;
      end
    end
  end

  // Local status read, delayed to line up with a one-cycle fabric.
  always_ff @(posedge clk) begin
    if (rst) begin
      loc1_q   <= 1'b0;
      loc2_q   <= 1'b0;
      loc1_dat <= '0;
      loc2_dat <= '0;
    end else begin
      loc1_q   <= cpu_req && !cpu_we && stat_hit;
      loc1_dat <= {{(DW-1){1'b0}}, ctl_q};
      loc2_q   <= loc1_q;
      loc2_dat <= loc1_dat;
    end
  end

  assign rsp_src = loc2_q ? loc2_dat : fab_rdata;

  endian_lane_swap #(.DW(DW)) u_rswap (
    .swap (rd_swap_q),
    .din  (rsp_src),
    .dout (rsp_cpu)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= fab_rvalid || loc2_q;
      if (fab_rvalid || loc2_q) cpu_rdata <= rsp_cpu;
    end
  end

endmodule

// File: rtl/endian_bridge_chk.sv
module endian_bridge_chk #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int STAT_WORD = 0
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_req,
  input logic [1:0]      cpu_size,
  input logic [AW-1:0]   cpu_addr,
  input logic [DW-1:0]   cpu_wdata,
  input logic            fab_req,
  input logic [DW/8-1:0] fab_be,
  input logic [DW-1:0]   fab_wdata,
  input logic            fab_rvalid,
  input logic            cpu_rvalid,
  input logic            mode_q,
  input logic            swap
);
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);
  localparam int IW = AW - 1 - LB;

  logic is_stat;
  assign is_stat = cpu_addr[AW-1] && (cpu_addr[AW-2:LB] == IW'(STAT_WORD));

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));

  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    fab_req && !$past(swap) |-> fab_wdata == $past(cpu_wdata));

  p_rev_r4: assert property (@(posedge clk) disable iff (rst)
    fab_req && $past(swap) |-> fab_wdata[7:0] == $past(cpu_wdata[DW-1 -: 8]));

  p_be_count_r6: assert property (@(posedge clk) disable iff (rst)
    fab_req |-> $countones(fab_be) == (32'd1 << $past(cpu_size)));

  p_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    fab_rvalid |=> cpu_rvalid);

  p_fwd_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !is_stat |=> fab_req);

  p_local_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_req && is_stat |=> !fab_req);

endmodule

bind cpu_endian_bridge endian_bridge_chk #(
  .AW(AW), .DW(DW), .STAT_WORD(STAT_WORD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_req    (cpu_req),
  .cpu_size   (cpu_size),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .fab_req    (fab_req),
  .fab_be     (fab_be),
  .fab_wdata  (fab_wdata),
  .fab_rvalid (fab_rvalid),
  .cpu_rvalid (cpu_rvalid),
  .mode_q     (mode_q),
  .swap       (swap)
);

// File: tb/tb_cpu_endian_bridge.sv
`timescale 1ns/1ps
module tb_cpu_endian_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        endian_pin = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        fab_req, fab_we, fab_is_reg;
  logic [15:0] fab_addr;
  logic [3:0]  fab_be;
  logic [31:0] fab_wdata;
  logic        fab_rvalid = 1'b0;
  logic [31:0] fab_rdata = '0;

  int n_chk = 0, n_bad = 0;
  logic        cur_mode = 1'b0, cur_ctl = 1'b0;
  logic        s_req, s_isreg;
  logic [15:0] s_addr;
  logic [3:0]  s_be;
  logic [31:0] s_wd, s_rd;
  logic        s_rv_early, s_rv;

  always #4 clk = ~clk;

  cpu_endian_bridge dut (
    .clk(clk), .rst(rst), .endian_pin(endian_pin),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .fab_req(fab_req), .fab_we(fab_we), .fab_is_reg(fab_is_reg),
    .fab_addr(fab_addr), .fab_be(fab_be), .fab_wdata(fab_wdata),
    .fab_rvalid(fab_rvalid), .fab_rdata(fab_rdata)
  );

  // Little-endian memory model: answers one edge after fab_req.
  logic [7:0] mem [0:255];
  initial for (int k = 0; k < 256; k++) mem[k] = 8'h00;

  always @(posedge clk) begin
    fab_rvalid <= 1'b0;
    if (fab_req) begin
      if (fab_we) begin
        for (int j = 0; j < 4; j++)
          if (fab_be[j]) mem[{fab_is_reg, fab_addr[6:2], 2'(j)}] <= fab_wdata[8*j +: 8];
      end else begin
        fab_rvalid <= 1'b1;
        for (int j = 0; j < 4; j++)
          fab_rdata[8*j +: 8] <= mem[{fab_is_reg, fab_addr[6:2], 2'(j)}];
      end
    end
  end

  typedef struct packed {
    logic        mode;
    logic        ctl;
    logic [1:0]  size;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [1:0]  lo;
    logic [3:0]  be;
    logic [31:0] fwd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 1'b0, 2'd2, 16'h0020, 32'hA1B2C3D4, 2'd0, 4'hF, 32'hA1B2C3D4},
    '{1'b0, 1'b0, 2'd1, 16'h0022, 32'h55660000, 2'd2, 4'hC, 32'h55660000},
    '{1'b0, 1'b0, 2'd0, 16'h0021, 32'h0000EE00, 2'd1, 4'h2, 32'h0000EE00},
    '{1'b0, 1'b0, 2'd2, 16'h8014, 32'h0BADF00D, 2'd0, 4'hF, 32'h0BADF00D},
    '{1'b0, 1'b1, 2'd0, 16'h0023, 32'h99000000, 2'd3, 4'h8, 32'h99000000},
    '{1'b0, 1'b1, 2'd2, 16'h0024, 32'h12345678, 2'd0, 4'hF, 32'h12345678},
    '{1'b1, 1'b0, 2'd2, 16'h0024, 32'h01020304, 2'd0, 4'hF, 32'h01020304},
    '{1'b1, 1'b0, 2'd1, 16'h0026, 32'hBEEF0000, 2'd2, 4'hC, 32'hBEEF0000},
    '{1'b1, 1'b1, 2'd2, 16'h0028, 32'hCAFEF00D, 2'd0, 4'hF, 32'h0DF0FECA},
    '{1'b1, 1'b1, 2'd1, 16'h0028, 32'h00001234, 2'd2, 4'hC, 32'h34120000},
    '{1'b1, 1'b1, 2'd1, 16'h002E, 32'hABCD0000, 2'd0, 4'h3, 32'h0000CDAB},
    '{1'b1, 1'b1, 2'd0, 16'h0030, 32'h0000005A, 2'd3, 4'h8, 32'h5A000000},
    '{1'b1, 1'b1, 2'd0, 16'h0031, 32'h00006B00, 2'd2, 4'h4, 32'h006B0000},
    '{1'b1, 1'b1, 2'd0, 16'h0033, 32'h7C000000, 2'd0, 4'h1, 32'h0000007C},
    '{1'b1, 1'b1, 2'd2, 16'h8010, 32'h11223344, 2'd0, 4'hF, 32'h44332211}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cpu_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] m = '0;
    for (int j = 0; j < 4; j++)
      if ((j >> sz) == (int'(lo) >> sz)) m[8*j +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic do_reset(input logic m);
    @(negedge clk);
    endian_pin = m;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_mode = m;
    cur_ctl  = 1'b0;
  endtask

  // Drive at a falling edge; fabric outputs sampled one falling edge later.
  task automatic do_write(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    s_req = fab_req; s_addr = fab_addr; s_be = fab_be; s_wd = fab_wdata; s_isreg = fab_is_reg;
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [15:0] a);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = sz; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    s_req = fab_req; s_addr = fab_addr; s_be = fab_be;
    @(negedge clk);
    s_rv_early = cpu_rvalid;
    @(negedge clk);
    s_rv = cpu_rvalid; s_rd = cpu_rdata;
  endtask

  task automatic set_ctl(input logic c);
    do_write(2'd2, 16'h8000, c ? 32'h01000001 : 32'h0);
    cur_ctl = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R2: reset state and status read in little mode
    check("R8 reset rvalid", 32'(cpu_rvalid), 32'd0);
    check("R10 reset fab_req", 32'(fab_req), 32'd0);
    do_read(2'd2, 16'h8000);
    check("R2 ctl reset value", s_rd, 32'h0);
    check("R8 status rvalid early", 32'(s_rv_early), 32'd0);
    check("R8 status rvalid", 32'(s_rv), 32'd1);
    check("R10 status read not forwarded", 32'(s_req), 32'd0);

    // Table walk over all mode / control combinations
    for (int v = 0; v < NV; v++) begin
      string tg;
      if (VEC[v].mode != cur_mode) do_reset(VEC[v].mode);
      if (VEC[v].ctl != cur_ctl) set_ctl(VEC[v].ctl);
      tg = (VEC[v].mode && VEC[v].ctl) ? "R4" : "R3";
      do_write(VEC[v].size, VEC[v].addr, VEC[v].wd);
      check($sformatf("%s data v%0d", tg, v), s_wd, VEC[v].fwd);
      check($sformatf("R5 addr v%0d", v), 32'(s_addr), 32'({VEC[v].addr[15:2], VEC[v].lo}));
      check($sformatf("R6 be v%0d", v), 32'(s_be), 32'(VEC[v].be));
      check($sformatf("R10 is_reg v%0d", v), 32'(s_isreg), 32'(VEC[v].addr[15]));
      do_read(VEC[v].size, VEC[v].addr);
      check($sformatf("R7 readback v%0d", v),
            s_rd & cpu_mask(VEC[v].size, VEC[v].addr[1:0]),
            VEC[v].wd & cpu_mask(VEC[v].size, VEC[v].addr[1:0]));
      check($sformatf("R8 rvalid v%0d", v), 32'({s_rv_early, s_rv}), 32'b01);
    end

    // R2 / R7: status word seen through conversion (mode big, ctl set)
    do_read(2'd2, 16'h8000);
    check("R2 R7 status swapped", s_rd, 32'h01000000);

    // R1: strap change after reset is ignored
    endian_pin = 1'b0;
    do_write(2'd0, 16'h0030, 32'h0000005A);
    check("R1 pin ignored addr", 32'(s_addr[1:0]), 32'd3);
    check("R1 pin ignored be", 32'(s_be), 32'h8);
    endian_pin = 1'b1;

    // R9: clearing the bit affects the next transfer at once
    set_ctl(1'b0);
    check("R10 status write not forwarded", 32'(s_req), 32'd0);
    do_write(2'd0, 16'h0030, 32'h0000005A);
    check("R9 cleared be", 32'(s_be), 32'h1);
    check("R9 cleared data", s_wd, 32'h0000005A);
    set_ctl(1'b1);
    do_write(2'd0, 16'h0030, 32'h0000005A);
    check("R9 set be", 32'(s_be), 32'h8);

    // R7: little-endian memory image read by a converting CPU
    do_reset(1'b0);
    do_read(2'd2, 16'h8000);
    check("R2 ctl cleared by reset", s_rd, 32'h0);
    do_write(2'd2, 16'h0040, 32'h11223344);
    do_reset(1'b1);
    set_ctl(1'b1);
    do_read(2'd0, 16'h0040);
    check("R7 byte 0", 32'(s_rd[7:0]), 32'h11);
    do_read(2'd0, 16'h0043);
    check("R7 byte 3", 32'(s_rd[31:24]), 32'h44);
    do_read(2'd1, 16'h0042);
    check("R7 half 2", 32'(s_rd[31:16]), 32'h4433);
    check("R5 half read addr", 32'(s_addr[1:0]), 32'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule